// File: doc/BRIEF.md
# Programmable Serial Input Glitch Filter

This block removes short spikes from the two inputs of a serial peripheral: the serial clock pin and the data-in pin. Which pin counts as data-in depends on the bus role. In two-wire mode it is the bidirectional data pin. In SPI master mode it is the slave-out pin. In SPI slave mode it is the master-out pin. Each pin first passes through a two-flop synchronizer. A counter then keeps the new level off the output until that level has held for longer than a tolerance window measured in system clocks.

A two-bit mode field picks the window. The choices are none, narrow (50 ns) or wide (100 ns). The nanosecond widths become cycle counts by rounding up the division by `CLK_PERIOD_NS`. After a change to the filtering setup, a settled flag drops. It rises again once ten times the selected window has passed. The controller uses this flag to decide when it may enable the serial interface.

Top module: `serial_glitch_filter`

## Requirements
- R1: With `mode_i` = 2'b00 the filters are bypassed. A pin level driven just before a rising edge appears on its output after exactly 3 rising edges, and this holds even for a one-cycle pulse. While bypassed, `settled_o` stays 1.
- R2: `mode_i` = 2'b01 behaves exactly like 2'b00.
- R3: `mode_i` = 2'b10 sets the window to T = ceil(50 / CLK_PERIOD_NS) cycles, which is 10 at the default period. A pulse held for T cycles or fewer never reaches the output. A level held for at least T+1 cycles appears after exactly T+3 rising edges.
- R4: `mode_i` = 2'b11 uses T = ceil(100 / CLK_PERIOD_NS) cycles, which is 20 at the default period, with the same rejection and latency rules as R3.
- R5: The clock filter always takes `scl_pin_i`. The data filter takes `sda_pin_i` when `twi_mode_i` = 1. Otherwise it takes `miso_pin_i` when `spi_master_i` = 1, and `mosi_pin_i` when `spi_master_i` = 0. The pins that are not selected have no effect on `data_filt_o`.
- R6: `rst` clears the mode register to bypass, clears both outputs to 0 and sets `settled_o` to 1. While `soft_rst_i` = 1 the mode register is held at bypass. When it is released with a filtering mode on `mode_i`, that counts as a mode change.
- R7: On the rising edge that registers a change of `mode_i` to 2'b10 or 2'b11 (this includes narrow to wide), `settled_o` goes to 0. It returns to 1 exactly 10·T rising edges later.
- R8: A change of `cpol_i` or `twi_mode_i` while a filtering mode is active restarts the R7 settling. The same change in bypass, or a change of `spi_master_i`, leaves `settled_o` unchanged.
- R9: On the edge that registers any mode change, each filter output loads the current synchronized pin level and its spike counter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst_i | input | 1 | Software reset; holds the filter mode at bypass |
| mode_i | input | 2 | Filter mode: 00/01 bypass, 10 narrow, 11 wide |
| cpol_i | input | 1 | Clock polarity configuration bit |
| twi_mode_i | input | 1 | Bus type: 1 two-wire, 0 SPI |
| spi_master_i | input | 1 | SPI role: 1 master, 0 slave |
| scl_pin_i | input | 1 | Raw serial clock pin |
| sda_pin_i | input | 1 | Raw two-wire data pin |
| miso_pin_i | input | 1 | Raw slave-out pin |
| mosi_pin_i | input | 1 | Raw master-out pin |
| clk_filt_o | output | 1 | Filtered serial clock |
| data_filt_o | output | 1 | Filtered selected data input |
| settled_o | output | 1 | High when the interface may be enabled safely |

## Verification
The hardest case to reach is a mode change that lands while a spike counter is partway through its window. Only then does the reload on that edge show up at the pins, as the output jumping to the synchronized level. The bench reaches this state with a directed sequence: it raises the pin in narrow mode, waits fewer than T+3 edges, and switches to wide mode. Random pulse trains follow. Their run lengths straddle T, so runs of exactly T and T+1 cycles occur in every mode. A bench function scores each train from its run lengths alone.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

    typedef enum logic [1:0] {
        FM_BYPASS = 2'b00,
        FM_RSVD   = 2'b01,
        FM_NARROW = 2'b10,
        FM_WIDE   = 2'b11
    } filt_mode_e;

    typedef enum logic [1:0] {
        SRC_TWI     = 2'b00,
        SRC_SPI_MST = 2'b01,
        SRC_SPI_SLV = 2'b10
    } data_src_e;

    typedef struct packed {
        filt_mode_e mode;
        logic       cpol;
        logic       twi;
        data_src_e  src;
    } cfg_t;

    localparam int N_LANES     = 2;
    localparam int LANE_CLK    = 0;
    localparam int LANE_DAT    = 1;
    localparam int SYNC_STAGES = 2;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic data_src_e pick_src(input logic twi, input logic master);
        if (twi)    return SRC_TWI;
        if (master) return SRC_SPI_MST;
        return SRC_SPI_SLV;
    endfunction

    function automatic logic is_filtering(input filt_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/sgf_sync.sv
module sgf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sgf_spike_filter.sv
module sgf_spike_filter
    import sgf_pkg::*;
#(
    parameter int TOL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic [TOL_W-1:0] tol_i,
    input  logic             reload_i,
    output logic             out_o
);
    logic             sync_lvl;
    logic             out_q;
    logic [TOL_W-1:0] cnt_q;

    sgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (sync_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (reload_i) begin
            out_q <= sync_lvl;
            cnt_q <= '0;
        end else if (sync_lvl == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q >= tol_i) begin
            out_q <= sync_lvl;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign out_o = out_q;

    // R9: the output only ever moves to a level the synchronizer presented
    assert_out_src_R9: assert property (@(posedge clk) disable iff (rst)
        (out_q != $past(out_q)) |-> (out_q == $past(sync_lvl)));

    // R3 / R4: the run counter never passes the window
    assert_cnt_cap_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= tol_i);

    // R1: with a zero window the output tracks the synchronizer one edge later
    assert_bypass_follow_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(tol_i) == '0) |-> (out_q == $past(sync_lvl)));

endmodule

// File: rtl/sgf_settle_monitor.sv
module sgf_settle_monitor #(
    parameter int TOL_W       = 5,
    parameter int SET_W       = 8,
    parameter int SETTLE_MULT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qualify_i,
    input  logic [TOL_W-1:0] tol_i,
    output logic             settled_o
);
    logic             settled_q;
    logic [SET_W-1:0] cnt_q;
    logic [SET_W-1:0] target;

    always_comb target = SET_W'(SETTLE_MULT * int'(tol_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            settled_q <= 1'b1;
            cnt_q     <= '0;
        end else if (qualify_i) begin
            settled_q <= 1'b0;
            cnt_q     <= '0;
        end else if (tol_i == '0) begin
            settled_q <= 1'b1;
            cnt_q     <= '0;
        end else if (!settled_q) begin
            if (cnt_q == target - 1'b1) begin
                settled_q <= 1'b1;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign settled_o = settled_q;

    // R7: the flag only drops because of a qualifying change
    assert_fall_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(settled_q) |-> $past(qualify_i));

    // R1: with no filtering selected the flag is high
    assert_bypass_high_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(tol_i) == '0) |-> settled_q);

    // R7: a filtered-mode rise only happens at the end of the full window
    assert_rise_window_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(settled_q) && ($past(tol_i) != '0)) |-> ($past(cnt_q) == $past(target) - 1'b1));

endmodule

// File: rtl/serial_glitch_filter.sv
module serial_glitch_filter
    import sgf_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned NARROW_NS     = 50,
    parameter int unsigned WIDE_NS       = 100,
    parameter int unsigned SETTLE_MULT   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst_i,
    input  logic [1:0] mode_i,
    input  logic       cpol_i,
    input  logic       twi_mode_i,
    input  logic       spi_master_i,
    input  logic       scl_pin_i,
    input  logic       sda_pin_i,
    input  logic       miso_pin_i,
    input  logic       mosi_pin_i,
    output logic       clk_filt_o,
    output logic       data_filt_o,
    output logic       settled_o
);
    localparam int unsigned NARROW_CYC = ceil_div(NARROW_NS, CLK_PERIOD_NS);
    localparam int unsigned WIDE_CYC   = ceil_div(WIDE_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC    = (WIDE_CYC > NARROW_CYC) ? WIDE_CYC : NARROW_CYC;
    localparam int          TOL_W      = $clog2(MAX_CYC + 1);
    localparam int          SET_W      = $clog2(SETTLE_MULT * MAX_CYC + 1);
    localparam cfg_t        RST_CFG    = '{mode: FM_BYPASS, cpol: 1'b0, twi: 1'b0, src: SRC_SPI_SLV};

    function automatic logic [TOL_W-1:0] tol_for(input filt_mode_e m);
        case (m)
            FM_NARROW: return TOL_W'(NARROW_CYC);
            FM_WIDE:   return TOL_W'(WIDE_CYC);
            default:   return '0;
        endcase
    endfunction

    cfg_t             cfg_q, cfg_nx;
    logic             mode_chg, bus_chg, qualify;
    logic [TOL_W-1:0] tol_q, tol_nx;
    logic             data_pin;
    logic [N_LANES-1:0] lane_pin, lane_out;

    always_comb begin
        cfg_nx.mode = soft_rst_i ? FM_BYPASS : filt_mode_e'(mode_i);
        cfg_nx.cpol = cpol_i;
        cfg_nx.twi  = twi_mode_i;
        cfg_nx.src  = pick_src(twi_mode_i, spi_master_i);
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= RST_CFG;
        else     cfg_q <= cfg_nx;
    end

    always_comb begin
        mode_chg = (cfg_nx.mode != cfg_q.mode);
        bus_chg  = (cfg_nx.cpol != cfg_q.cpol) || (cfg_nx.twi != cfg_q.twi);
        qualify  = is_filtering(cfg_nx.mode) && (mode_chg || bus_chg);
        tol_q    = tol_for(cfg_q.mode);
        tol_nx   = tol_for(cfg_nx.mode);
    end

    always_comb begin
        case (cfg_q.src)
            SRC_TWI:     data_pin = sda_pin_i;
            SRC_SPI_MST: data_pin = miso_pin_i;
            default:     data_pin = mosi_pin_i;
        endcase
    end

    assign lane_pin[LANE_CLK] = scl_pin_i;
    assign lane_pin[LANE_DAT] = data_pin;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        sgf_spike_filter #(.TOL_W(TOL_W)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .pin_i    (lane_pin[g]),
            .tol_i    (tol_q),
            .reload_i (mode_chg),
            .out_o    (lane_out[g])
        );
    end

    sgf_settle_monitor #(
        .TOL_W       (TOL_W),
        .SET_W       (SET_W),
        .SETTLE_MULT (SETTLE_MULT)
    ) u_settle (
        .clk       (clk),
        .rst       (rst),
        .qualify_i (qualify),
        .tol_i     (tol_nx),
        .settled_o (settled_o)
    );

    assign clk_filt_o  = lane_out[LANE_CLK];
    assign data_filt_o = lane_out[LANE_DAT];

    // R6: a software reset leaves the mode register in bypass
    assert_soft_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst_i) |-> (cfg_q.mode == FM_BYPASS));

    // R2: the reserved code never selects a window
    assert_rsvd_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == FM_RSVD) |-> (tol_q == '0));

endmodule

// File: tb/serial_glitch_filter_bench.sv
module serial_glitch_filter_bench;
    logic       clk = 1'b0;
    logic       rst, soft_rst, cpol, twi, master;
    logic [1:0] mode;
    logic       scl, sda, miso, mosi;
    logic       clk_f, data_f, settled;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    serial_glitch_filter u_serial_glitch_filter (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst), .mode_i(mode),
        .cpol_i(cpol), .twi_mode_i(twi), .spi_master_i(master),
        .scl_pin_i(scl), .sda_pin_i(sda), .miso_pin_i(miso), .mosi_pin_i(mosi),
        .clk_filt_o(clk_f), .data_filt_o(data_f), .settled_o(settled)
    );

    function automatic int tol_of(input logic [1:0] m);
        if (m == 2'b10) return (50 + 5 - 1) / 5;
        if (m == 2'b11) return (100 + 5 - 1) / 5;
        return 0;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive_data(input logic v);
        if (twi)         sda  = v;
        else if (master) miso = v;
        else             mosi = v;
    endtask

    task automatic go_mode(input logic [1:0] m);
        mode = m;
        step(10 * tol_of(m) + 3);
    endtask

    // Random run-length trains; expected result from run lengths only
    task automatic train(input logic [1:0] m);
        int   t = tol_of(m);
        logic base, lvl, mc, md;
        int   len;
        twi    = 1'($urandom);
        master = 1'($urandom);
        go_mode(m);
        base = 1'($urandom);
        scl = base; drive_data(~base);
        step(t + 4);
        mc = base; md = ~base; lvl = base;
        for (int k = 0; k < 7; k++) begin
            lvl = ~lvl;
            len = (k == 6) ? t + 4 : 1 + int'($urandom % (2 * t + 3));
            scl = lvl; drive_data(~lvl);
            step(len);
            if (lvl != mc && len >= t + 1) mc = lvl;
            if (~lvl != md && len >= t + 1) md = ~lvl;
        end
        chk($sformatf("R3/R4 random train clk mode=%b", m), clk_f, mc);
        chk($sformatf("R5 random train data mode=%b twi=%b mst=%b", m, twi, master), data_f, md);
    endtask

    // Directed pulse test in a filtering mode: T rejected, T+1 passes at T+3
    task automatic pulse_edge(input logic [1:0] m, input string tag);
        int t = tol_of(m);
        go_mode(m);
        scl = 1'b0; step(t + 4);
        scl = 1'b1; step(t);
        scl = 1'b0; step(t + 6);
        chk({tag, " pulse of T cycles rejected"}, clk_f, 1'b0);
        scl = 1'b1; step(t + 2);
        chk({tag, " output still low at T+2 edges"}, clk_f, 1'b0);
        step(1);
        chk({tag, " output high at T+3 edges"}, clk_f, 1'b1);
        scl = 1'b0; step(t + 4);
    endtask

    initial begin
        int t;
        rst = 1'b1; soft_rst = 1'b0; mode = 2'b00; cpol = 1'b0;
        twi = 1'b0; master = 1'b0;
        scl = 1'b0; sda = 1'b0; miso = 1'b0; mosi = 1'b0;
        void'($urandom(32'd4242));
        step(3);
        rst = 1'b0;
        step(1);
        chk("R6 reset settled", settled, 1'b1);
        chk("R6 reset clk out", clk_f, 1'b0);
        chk("R6 reset data out", data_f, 1'b0);

        // R1: bypass latency and single-cycle pulse
        scl = 1'b1; step(1); scl = 1'b0; step(1);
        chk("R1 bypass before latency", clk_f, 1'b0);
        step(1);
        chk("R1 bypass one-cycle pulse passes", clk_f, 1'b1);
        step(1);
        chk("R1 bypass pulse ends", clk_f, 1'b0);
        chk("R1 bypass settled", settled, 1'b1);

        // R2: reserved code
        mode = 2'b01; step(2);
        chk("R2 reserved settled", settled, 1'b1);
        scl = 1'b1; step(1); scl = 1'b0; step(2);
        chk("R2 reserved one-cycle pulse passes", clk_f, 1'b1);

        // R5: source mux in bypass
        mode = 2'b00; step(4);
        twi = 1'b1; sda = 1'b1; miso = 1'b0; mosi = 1'b0; step(5);
        chk("R5 two-wire selects sda", data_f, 1'b1);
        miso = 1'b1; mosi = 1'b1; sda = 1'b0; step(5);
        chk("R5 two-wire ignores miso/mosi", data_f, 1'b0);
        twi = 1'b0; master = 1'b1; step(5);
        chk("R5 master selects miso", data_f, 1'b1);
        miso = 1'b0; step(5);
        chk("R5 master follows miso", data_f, 1'b0);
        master = 1'b0; step(5);
        chk("R5 slave selects mosi", data_f, 1'b1);
        sda = 1'b1; miso = 1'b1; mosi = 1'b0; step(5);
        chk("R5 slave ignores sda/miso", data_f, 1'b0);
        sda = 1'b0; miso = 1'b0;

        // R3 / R4 directed thresholds
        pulse_edge(2'b10, "R3");
        pulse_edge(2'b11, "R4");

        // R7: settling window after bypass to narrow
        mode = 2'b00; step(3);
        t = tol_of(2'b10);
        mode = 2'b10; step(1);
        chk("R7 drop on mode change", settled, 1'b0);
        step(10 * t - 1);
        chk("R7 still low one edge early", settled, 1'b0);
        step(1);
        chk("R7 high after 10*T edges", settled, 1'b1);
        // narrow to wide also qualifies
        t = tol_of(2'b11);
        mode = 2'b11; step(1);
        chk("R7 drop on narrow to wide", settled, 1'b0);
        step(10 * t - 1);
        chk("R7 wide still low one edge early", settled, 1'b0);
        step(1);
        chk("R7 wide high after 10*T edges", settled, 1'b1);

        // R8: bus-type, polarity and role changes
        master = ~master; step(1);
        chk("R8 role change ignored", settled, 1'b1);
        cpol = ~cpol; step(1);
        chk("R8 polarity change restarts", settled, 1'b0);
        step(10 * t);
        chk("R8 settled again after polarity", settled, 1'b1);
        twi = ~twi; step(1);
        chk("R8 bus-type change restarts", settled, 1'b0);
        step(10 * t);
        mode = 2'b00; step(2);
        cpol = ~cpol; step(1);
        chk("R8 polarity change in bypass ignored", settled, 1'b1);

        // R9: reload in the middle of a count
        go_mode(2'b10);
        scl = 1'b0; step(15);
        scl = 1'b1; step(7);
        chk("R9 narrow counting not yet passed", clk_f, 1'b0);
        mode = 2'b11; step(1);
        chk("R9 mode change loads synchronized level", clk_f, 1'b1);
        scl = 1'b0; step(tol_of(2'b11));
        scl = 1'b1; step(6);
        chk("R9 wide window after reload", clk_f, 1'b1);
        scl = 1'b0; step(25);

        // R6: software reset
        soft_rst = 1'b1; step(1);
        chk("R6 soft reset forces bypass settled", settled, 1'b1);
        scl = 1'b1; step(1); scl = 1'b0; step(2);
        chk("R6 soft reset bypasses filter", clk_f, 1'b1);
        step(3);
        soft_rst = 1'b0; step(1);
        chk("R6 release with wide mode restarts settling", settled, 1'b0);
        step(210);

        // random trains
        for (int i = 0; i < 40; i++) begin
            logic [1:0] m = 2'($urandom);
            train(m);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule